// File: doc/BRIEF.md
# Short-Circuit Filter, Fault Latch and Diagnosis Encoder

This block is the protection core of an H-bridge gate driver. It receives one short-circuit comparator input and one undervoltage input for each of the four power switches, along with a single overtemperature warning input. From these it produces a per-switch inhibit vector for the gate sequencer and two active-low error flags that tell the host which class of fault is present.

A short-circuit comparator must stay asserted without a gap for a parameterised number of clock cycles before the block accepts it as a fault. A single deasserted cycle restarts that count from zero, so a train of short violations never adds up to a trip. Once a short circuit is confirmed, both switches of its half-bridge are blocked, and they stay blocked until reset or until a clear pulse arrives on the disable path. Undervoltage works differently: it blocks only the switch it concerns, and the block holds no memory of it, so the switch is released as soon as the condition ends. Overtemperature is reported on the flags and has no other effect.

Top module: `fault_diag_top`

## Requirements
- R1: After a synchronous reset, every inhibit output is 0 and both flag pull-downs are released (0).
- R2: A switch's short-circuit fault is latched once its comparator has been sampled high on FILT_CYC consecutive rising clock edges. The fault is visible after the FILT_CYC-th such edge.
- R3: Any cycle with the comparator low restarts that switch's count from zero. Repeated high runs of FILT_CYC-1 cycles never latch a fault.
- R4: A latched short-circuit fault persists after its comparator drops. It clears only on reset or on a cycle with `flt_clr` high, which also zeroes the persistence counters.
- R5: Switch index 2b is the high side of half-bridge b and index 2b+1 is its low side. A latched fault on either switch sets the inhibit of both switches of that half-bridge and of no other.
- R6: An undervoltage input sets the inhibit of its own switch in the same cycle and leaves the other switches alone. The inhibit falls again as soon as the input falls.
- R7: Flag encoding (1 = pull low): no fault gives a=0,b=0; overtemperature only gives a=0,b=1; short-circuit shutdown gives a=1,b=0; undervoltage shutdown gives a=1,b=1.
- R8: The priority order is undervoltage over short circuit over overtemperature.
- R9: Overtemperature never sets any inhibit output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flt_clr | input | 1 | Clear pulse for latched short-circuit faults |
| sc_cmp | input | 4 | Short-circuit comparator per switch |
| uv_det | input | 4 | Undervoltage detect per switch |
| ot_warn | input | 1 | Overtemperature warning |
| sw_inhibit | output | 4 | Per-switch gate inhibit |
| flag_a_pull | output | 1 | Pull-down enable for error flag A |
| flag_b_pull | output | 1 | Pull-down enable for error flag B |

## Verification
The bench builds the block with FILT_CYC = 8. At that value, runs of one cycle short of the filter time and runs exactly at it can both be driven and compared within a few dozen cycles. The short filter also makes it practical to repeat sub-threshold bursts, which shows that no time accumulates across them. A filter of realistic length would allow neither test in a short run. The bridge count keeps its default of two, so the bench can trip a fault on one half-bridge and observe that the other half-bridge is untouched.

// File: rtl/fault_diag_pkg.sv
package fault_diag_pkg;

    typedef enum logic [1:0] {
        DIAG_NONE = 2'd0,
        DIAG_OT   = 2'd1,
        DIAG_SC   = 2'd2,
        DIAG_UV   = 2'd3
    } diag_class_e;

    typedef struct packed {
        logic pull_a;
        logic pull_b;
    } flag_drive_t;

    function automatic diag_class_e classify(input logic uv_any,
                                             input logic sc_any,
                                             input logic ot);
        if (uv_any)      return DIAG_UV;
        else if (sc_any) return DIAG_SC;
        else if (ot)     return DIAG_OT;
        else             return DIAG_NONE;
    endfunction

endpackage

// File: rtl/sc_guard.sv
module sc_guard #(
    parameter int FILT_CYC = 150
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic cmp,
    output logic tripped
);
    localparam int CW = $clog2(FILT_CYC + 1);
    localparam logic [CW-1:0] LIM = CW'(FILT_CYC - 1);

    logic [CW-1:0] run_cnt;
    logic          hit;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            run_cnt <= '0;
            hit     <= 1'b0;
        end else if (!cmp) begin
            run_cnt <= '0;
        end else if (!hit) begin
            if (run_cnt == LIM) hit <= 1'b1;
            else                run_cnt <= run_cnt + 1'b1;
        end
    end

    assign tripped = hit;

    // R2
    trip_needs_cmp_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(hit) |-> $past(cmp));

    // R4
    latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && !clr) |=> hit);

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        run_cnt <= LIM);

endmodule

// File: rtl/diag_encoder.sv
module diag_encoder
    import fault_diag_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        uv_any,
    input  logic        sc_any,
    input  logic        ot,
    output flag_drive_t drive
);
    diag_class_e cls;

    always_comb begin
        cls = classify(uv_any, sc_any, ot);
        unique case (cls)
            DIAG_NONE: drive = '{pull_a: 1'b0, pull_b: 1'b0};
            DIAG_OT:   drive = '{pull_a: 1'b0, pull_b: 1'b1};
            DIAG_SC:   drive = '{pull_a: 1'b1, pull_b: 1'b0};
            default:   drive = '{pull_a: 1'b1, pull_b: 1'b1};
        endcase
    end

    // R8
    uv_wins_chk: assert property (@(posedge clk) disable iff (rst)
        uv_any |-> (drive.pull_a && drive.pull_b));

    // R7
    quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!uv_any && !sc_any && !ot) |-> (!drive.pull_a && !drive.pull_b));

endmodule

// File: rtl/fault_diag_top.sv
module fault_diag_top
    import fault_diag_pkg::*;
#(
    parameter int FILT_CYC   = 150,
    parameter int NUM_BRIDGE = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    flt_clr,
    input  logic [2*NUM_BRIDGE-1:0] sc_cmp,
    input  logic [2*NUM_BRIDGE-1:0] uv_det,
    input  logic                    ot_warn,
    output logic [2*NUM_BRIDGE-1:0] sw_inhibit,
    output logic                    flag_a_pull,
    output logic                    flag_b_pull
);
    localparam int NSW = 2 * NUM_BRIDGE;

    logic [NSW-1:0]        sw_trip;
    logic [NSW-1:0]        bridge_block;
    flag_drive_t           fdrv;

    for (genvar s = 0; s < NSW; s++) begin : g_sw
        sc_guard #(.FILT_CYC(FILT_CYC)) u_guard (
            .clk     (clk),
            .rst     (rst),
            .clr     (flt_clr),
            .cmp     (sc_cmp[s]),
            .tripped (sw_trip[s])
        );
    end

    for (genvar b = 0; b < NUM_BRIDGE; b++) begin : g_br
        assign bridge_block[2*b]   = sw_trip[2*b] | sw_trip[2*b+1];
        assign bridge_block[2*b+1] = sw_trip[2*b] | sw_trip[2*b+1];
    end

    assign sw_inhibit = bridge_block | uv_det;

    diag_encoder u_enc (
        .clk    (clk),
        .rst    (rst),
        .uv_any (|uv_det),
        .sc_any (|sw_trip),
        .ot     (ot_warn),
        .drive  (fdrv)
    );

    assign flag_a_pull = fdrv.pull_a;
    assign flag_b_pull = fdrv.pull_b;

    // R6
    uv_local_chk: assert property (@(posedge clk) disable iff (rst)
        (sw_inhibit & uv_det) == uv_det);

    // R9
    ot_no_block_chk: assert property (@(posedge clk) disable iff (rst)
        (ot_warn && uv_det == '0 && sw_trip == '0) |-> (sw_inhibit == '0));

    // R5
    pair_block_chk: assert property (@(posedge clk) disable iff (rst)
        (uv_det == '0) |-> (sw_inhibit == bridge_block));

endmodule

// File: tb/test_fault_diag_top.sv
module test_fault_diag_top;
    localparam int FC = 8;

    logic       clk = 1'b0;
    logic       rst, flt_clr, ot_warn;
    logic [3:0] sc_cmp, uv_det, sw_inhibit;
    logic       flag_a_pull, flag_b_pull;
    int n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    fault_diag_top #(.FILT_CYC(FC), .NUM_BRIDGE(2)) i_fault_diag_top (
        .clk(clk), .rst(rst), .flt_clr(flt_clr), .sc_cmp(sc_cmp),
        .uv_det(uv_det), .ot_warn(ot_warn), .sw_inhibit(sw_inhibit),
        .flag_a_pull(flag_a_pull), .flag_b_pull(flag_b_pull));

    // {uv[3:0], ot, inh[3:0], a, b}, no short latched
    localparam logic [10:0] VEC [8] = '{
        {4'b0000, 1'b0, 4'b0000, 1'b0, 1'b0},
        {4'b0000, 1'b1, 4'b0000, 1'b0, 1'b1},
        {4'b0001, 1'b0, 4'b0001, 1'b1, 1'b1},
        {4'b0100, 1'b1, 4'b0100, 1'b1, 1'b1},
        {4'b1000, 1'b0, 4'b1000, 1'b1, 1'b1},
        {4'b0110, 1'b0, 4'b0110, 1'b1, 1'b1},
        {4'b1111, 1'b1, 4'b1111, 1'b1, 1'b1},
        {4'b0000, 1'b0, 4'b0000, 1'b0, 1'b0}
    };

    task automatic check(input string req, input logic [3:0] inh,
                         input logic a, input logic b);
        n_chk++;
        if (sw_inhibit !== inh || flag_a_pull !== a || flag_b_pull !== b) begin
            n_bad++;
            $display("FAIL %s: got inh=%b a=%b b=%b, expected inh=%b a=%b b=%b",
                     req, sw_inhibit, flag_a_pull, flag_b_pull, inh, a, b);
        end
    endtask

    task automatic run_sc(input int idx, input int cyc);
        sc_cmp[idx] = 1'b1;
        repeat (cyc) @(negedge clk);
        sc_cmp[idx] = 1'b0;
    endtask

    initial begin
        #200000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: got hung run, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1; flt_clr = 1'b0; ot_warn = 1'b0; sc_cmp = '0; uv_det = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 reset", 4'b0000, 1'b0, 1'b0);

        // R6 R7 R8 R9 table
        for (int k = 0; k < 8; k++) begin
            uv_det  = VEC[k][10:7];
            ot_warn = VEC[k][6];
            @(negedge clk);
            check("R6/R7/R8/R9 vec", VEC[k][5:2], VEC[k][1], VEC[k][0]);
        end

        // R3: repeated sub-threshold runs never trip
        for (int k = 0; k < 3; k++) begin
            run_sc(0, FC - 1);
            @(negedge clk);
            check("R3 short run", 4'b0000, 1'b0, 1'b0);
        end

        // R2 R5: exactly FC edges trip bridge 0 only
        run_sc(1, FC);
        check("R2 R5 trip", 4'b0011, 1'b1, 1'b0);

        // R4: holds after comparator low
        repeat (5) @(negedge clk);
        check("R4 hold", 4'b0011, 1'b1, 1'b0);

        // R8: overtemp under short
        ot_warn = 1'b1; @(negedge clk);
        check("R8 sc over ot", 4'b0011, 1'b1, 1'b0);
        // R8: undervoltage on other bridge over short
        uv_det = 4'b0100; @(negedge clk);
        check("R8 uv over sc", 4'b0111, 1'b1, 1'b1);
        uv_det = 4'b0000; @(negedge clk);
        check("R6 uv recover", 4'b0011, 1'b1, 1'b0);

        // R4: clear
        flt_clr = 1'b1; @(negedge clk); flt_clr = 1'b0;
        check("R4 clear", 4'b0000, 1'b0, 1'b1);
        ot_warn = 1'b0;

        // R4: clear zeroes counters; R2 R5 bridge 1 high side
        sc_cmp[2] = 1'b1;
        repeat (FC - 2) @(negedge clk);
        flt_clr = 1'b1; @(negedge clk); flt_clr = 1'b0;
        repeat (FC - 1) @(negedge clk);
        check("R4 counter cleared", 4'b0000, 1'b0, 1'b0);
        @(negedge clk);
        sc_cmp[2] = 1'b0;
        check("R2 R5 bridge1 trip", 4'b1100, 1'b1, 1'b0);

        // R1: reset clears latch
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        check("R1 reset clears", 4'b0000, 1'b0, 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule